// File: doc/BRIEF.md
# Sample-Rate Ratio Tracker

This block sits in front of the interpolation filter of an asynchronous sample-rate converter. It never sees audio data. It counts master-clock cycles between consecutive input-sample strobes and, separately, between consecutive output-sample strobes. Each of the two period streams is smoothed by a first-order recursive average. The quotient of the two averages becomes an unsigned fixed-point ratio with 8 integer and 20 fractional bits: the number of input samples consumed per output sample.

A fill counter stands in for the occupancy of a 128-entry sample buffer. Input strobes raise it and output strobes lower it. On every output strobe a fractional phase accumulator advances by the ratio plus a small trim, and the trim is applied only when the fill strays from the centre. Together these form a digital phase-locked loop that keeps the buffer from running dry or overflowing. The top six bits of the phase pick one polyphase coefficient set.

A lock flag reports that the ratio has stayed steady over a long run of output samples while the buffer stayed in its safe band. A mode input chooses a light averaging gain for fast tracking or a heavy gain for strong jitter rejection.

Top module: `asrc_rate_tracker`

## Requirements
- R1: A period is the number of master-clock cycles between two consecutive strobes on the same side. It is 24 bits wide and saturates at its maximum. The first strobe after reset produces no measurement, so `ratio` stays 0 after one strobe on each side.
- R2: The first measurement on a side loads that side's average directly. Each later measurement m moves the average a by floor((m - a) / 2^S). S is 2 when `slow_mode` is 0 and 6 when it is 1, so the slow setting follows a rate step much more gradually.
- R3: `ratio` equals floor(out_avg * 2^20 / in_avg) and is 0 until both sides hold an average. A new value appears 3 clock edges after the strobe that caused it, and `ratio` does not change while both averages are unchanged.
- R4: A quotient of 256.0 or more saturates `ratio` at 2^28 - 1.
- R5: Buffer fill resets to 64 of 128. It rises by one on an input strobe and falls by one on an output strobe, is unchanged when both strobes arrive in the same cycle, and is clamped to 0..128.
- R6: Once `ratio` is valid, each output strobe adds the low 20 bits of `ratio` plus a trim to a 20-bit wrapping phase. `phase_idx` is phase bits [19:14] and changes on no other cycle.
- R7: The trim is +2^14 (one index step) when fill is above 80, -2^14 when fill is below 48, and 0 from 48 to 80 inclusive.
- R8: On each output strobe with a valid ratio, a lock counter advances if the ratio differs from its value at the previous output strobe by at most 256 LSB and fill is within 32..96. `locked` rises when the count reaches 256.
- R9: `locked` falls, and the count restarts, when fill leaves 32..96 or when an output strobe sees a larger ratio change.
- R10: During and right after reset, `ratio`, `phase_idx` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all periods are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | One-cycle pulse per incoming sample |
| out_strobe | input | 1 | One-cycle pulse per outgoing sample |
| slow_mode | input | 1 | 0 selects light averaging (fast tracking), 1 heavy averaging |
| ratio | output | 28 | Input-per-output rate ratio, unsigned 8.20 fixed point |
| phase_idx | output | 6 | Polyphase coefficient set selector |
| locked | output | 1 | Ratio steady and buffer fill inside its safe band |

## Verification
The assertions assume that the strobes are clean single-cycle pulses sampled on the master clock. They also assume that `slow_mode` does not change while a measurement is being folded into an average. The bench produces both strobes from cycle counters stepped on the falling clock edge and changes the mode only while reset is held. It compares `ratio` only when at least three edges have passed since the last strobe on either side, which leaves the measurement, average and division registers time to settle. Phase and lock checks rely on the same counters to place buffer fill on the intended side of each threshold.

// File: rtl/asrc_rt_pkg.sv
package asrc_rt_pkg;
  localparam int CNT_W   = 24;
  localparam int INT_W   = 8;
  localparam int FRAC_W  = 20;
  localparam int RATIO_W = INT_W + FRAC_W;
  localparam int IDX_W   = 6;
  localparam int QUO_W   = CNT_W + FRAC_W;

  typedef logic [CNT_W-1:0]   period_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [FRAC_W-1:0]  phase_t;

  localparam ratio_t RATIO_MAX = '1;

  // recursive average step: a + floor((m - a) / 2^sh)
  function automatic period_t iir_next(period_t avg, period_t meas, logic [4:0] sh);
    logic signed [CNT_W+1:0] d;
    logic signed [CNT_W+1:0] r;
    d = $signed({2'b00, meas}) - $signed({2'b00, avg});
    r = $signed({2'b00, avg}) + (d >>> sh);
    return r[CNT_W-1:0];
  endfunction

  // out_period / in_period in 8.20, saturating
  function automatic ratio_t ratio_of(period_t p_out, period_t p_in);
    logic [QUO_W-1:0] num;
    logic [QUO_W-1:0] q;
    if (p_in == '0) return '0;
    num = {p_out, {FRAC_W{1'b0}}};
    q   = num / {{FRAC_W{1'b0}}, p_in};
    if (q > {{(QUO_W-RATIO_W){1'b0}}, RATIO_MAX}) return RATIO_MAX;
    return q[RATIO_W-1:0];
  endfunction

  // buffer-fill trim added to the phase step
  function automatic phase_t trim_of(int unsigned fill, int unsigned lo,
                                     int unsigned hi, int unsigned sh);
    phase_t slot;
    slot = phase_t'(1) << sh;
    if (fill > hi) return slot;
    if (fill < lo) return phase_t'(0) - slot;
    return '0;
  endfunction

  function automatic ratio_t abs_diff(ratio_t a, ratio_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/asrc_period_meter.sv
module asrc_period_meter
  import asrc_rt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  output logic    meas_vld,
  output period_t meas
);
  logic    armed;
  period_t cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      meas     <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      if (strobe) begin
        cnt   <= period_t'(1);
        armed <= 1'b1;
        if (armed) begin
          meas     <= cnt;
          meas_vld <= 1'b1;
        end
      end else if (cnt != '1) begin
        cnt <= cnt + period_t'(1);
      end
    end
  end

  // R1: a measurement is never zero cycles long
  assert_meas_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> (meas != '0));
  // R1: the first strobe after reset yields nothing
  assert_first_strobe_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !armed) |=> !meas_vld);
endmodule

// File: rtl/asrc_period_avg.sv
module asrc_period_avg
  import asrc_rt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_vld,
  input  period_t    meas,
  input  logic [4:0] gain_sh,
  output period_t    avg,
  output logic       seeded
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg    <= '0;
      seeded <= 1'b0;
    end else if (meas_vld) begin
      avg    <= seeded ? iir_next(avg, meas, gain_sh) : meas;
      seeded <= 1'b1;
    end
  end

  // R2: the average moves only on a measurement
  assert_avg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> $stable(avg));
  // R2: an update lands between the old average and the new measurement
  assert_avg_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && seeded) |=>
      ((avg >= (($past(avg) < $past(meas)) ? $past(avg) : $past(meas))) &&
       (avg <= (($past(avg) > $past(meas)) ? $past(avg) : $past(meas)))));
endmodule

// File: rtl/asrc_buffer_level.sv
module asrc_buffer_level #(
  parameter int DEPTH  = 128,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic              out_stb,
  output logic [FILL_W-1:0] fill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= FILL_W'(DEPTH / 2);
    end else begin
      unique case ({in_stb, out_stb})
        2'b10: if (fill != FILL_W'(DEPTH)) fill <= fill + FILL_W'(1);
        2'b01: if (fill != '0) fill <= fill - FILL_W'(1);
        default: ;
      endcase
    end
  end

  // R5: fill never exceeds the buffer depth
  assert_fill_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));
  // R5: a write and a read in one cycle cancel
  assert_fill_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && out_stb) |=> $stable(fill));
endmodule

// File: rtl/asrc_phase_lock.sv
module asrc_phase_lock
  import asrc_rt_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int LOCK_N   = 256,
  parameter int LOCK_TOL = 256,
  parameter int TRIM_SH  = 14,
  localparam int FILL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_stb,
  input  logic              ratio_vld,
  input  ratio_t            ratio,
  input  logic [FILL_W-1:0] fill,
  output logic [IDX_W-1:0]  phase_idx,
  output logic              locked
);
  localparam int BAND_LO = DEPTH / 4;
  localparam int BAND_HI = (3 * DEPTH) / 4;
  localparam int DB_LO   = DEPTH / 2 - DEPTH / 8;
  localparam int DB_HI   = DEPTH / 2 + DEPTH / 8;
  localparam int LCNT_W  = $clog2(LOCK_N + 1);

  phase_t              phase;
  ratio_t              prev_ratio;
  logic [LCNT_W-1:0]   lcnt;

  // named internal events
  logic   step_evt;
  logic   in_band;
  logic   err_ok;
  phase_t trim;

  assign step_evt  = out_stb && ratio_vld;
  assign in_band   = (fill >= FILL_W'(BAND_LO)) && (fill <= FILL_W'(BAND_HI));
  assign err_ok    = abs_diff(ratio, prev_ratio) <= ratio_t'(LOCK_TOL);
  assign trim      = trim_of(32'(fill), DB_LO, DB_HI, TRIM_SH);
  assign phase_idx = phase[FRAC_W-1 -: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      prev_ratio <= '0;
    end else if (step_evt) begin
      phase      <= phase + ratio[FRAC_W-1:0] + trim;
      prev_ratio <= ratio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt   <= '0;
      locked <= 1'b0;
    end else if (!in_band) begin
      lcnt   <= '0;
      locked <= 1'b0;
    end else if (step_evt) begin
      if (err_ok) begin
        if (lcnt != LCNT_W'(LOCK_N)) lcnt <= lcnt + LCNT_W'(1);
        if (lcnt >= LCNT_W'(LOCK_N - 1)) locked <= 1'b1;
      end else begin
        lcnt   <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R6: the index moves only on an output step
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(phase_idx));
  // R8: lock is gained only on an output step
  assert_lock_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(step_evt));
  // R9: lock never survives a fill outside the safe band
  assert_lock_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> $past(in_band));
  // R9: a large ratio jump on a step drops lock
  assert_lock_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !err_ok) |=> !locked);
endmodule

// File: rtl/asrc_rate_tracker.sv
module asrc_rate_tracker
  import asrc_rt_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int FAST_SH  = 2,
  parameter int SLOW_SH  = 6,
  parameter int LOCK_N   = 256,
  parameter int LOCK_TOL = 256,
  parameter int TRIM_SH  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_strobe,
  input  logic               out_strobe,
  input  logic               slow_mode,
  output logic [RATIO_W-1:0] ratio,
  output logic [IDX_W-1:0]   phase_idx,
  output logic               locked
);
  localparam int SIDES  = 2;   // 0: input side, 1: output side
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [SIDES-1:0] strobes;
  logic [SIDES-1:0] meas_vld;
  logic [SIDES-1:0] seeded;
  period_t          meas [SIDES];
  period_t          avg  [SIDES];
  logic [4:0]       gain_sh;
  ratio_t           ratio_q;
  logic             ratio_vld;
  logic [FILL_W-1:0] fill;

  assign strobes = {out_strobe, in_strobe};
  assign gain_sh = slow_mode ? 5'(SLOW_SH) : 5'(FAST_SH);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    asrc_period_meter u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobes[s]),
      .meas_vld (meas_vld[s]),
      .meas     (meas[s])
    );
    asrc_period_avg u_avg (
      .clk      (clk),
      .rst_n    (rst_n),
      .meas_vld (meas_vld[s]),
      .meas     (meas[s]),
      .gain_sh  (gain_sh),
      .avg      (avg[s]),
      .seeded   (seeded[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= '0;
      ratio_vld <= 1'b0;
    end else begin
      ratio_q   <= (&seeded) ? ratio_of(avg[1], avg[0]) : '0;
      ratio_vld <= &seeded;
    end
  end

  asrc_buffer_level #(.DEPTH(DEPTH)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_stb  (in_strobe),
    .out_stb (out_strobe),
    .fill    (fill)
  );

  asrc_phase_lock #(
    .DEPTH    (DEPTH),
    .LOCK_N   (LOCK_N),
    .LOCK_TOL (LOCK_TOL),
    .TRIM_SH  (TRIM_SH)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_stb   (out_strobe),
    .ratio_vld (ratio_vld),
    .ratio     (ratio_q),
    .fill      (fill),
    .phase_idx (phase_idx),
    .locked    (locked)
  );

  assign ratio = ratio_q;

  // R3: steady averages give a steady ratio
  assert_ratio_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(avg[0]) && $stable(avg[1])) |=> $stable(ratio_q));
  // R3: no ratio before both sides have an average
  assert_ratio_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(seeded[0] && seeded[1]) |=> (ratio_q == '0));
endmodule

// File: tb/asrc_rate_tracker_tb.sv
module asrc_rate_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_strobe = 1'b0;
  logic        out_strobe = 1'b0;
  logic        slow = 1'b0;
  logic [27:0] ratio;
  logic [5:0]  phase_idx;
  logic        locked;

  int checks = 0;
  int failures = 0;

  asrc_rate_tracker u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_strobe  (in_strobe),
    .out_strobe (out_strobe),
    .slow_mode  (slow),
    .ratio      (ratio),
    .phase_idx  (phase_idx),
    .locked     (locked)
  );

  always #10 clk = ~clk;

  // strobe generator and independent model of the averages
  bit gen_on = 0;
  int tin = 10, tout = 10, in_ph = 0, out_ph = 0;
  int cyc = 0, in_age = 100, out_age = 100;
  bit mi_arm, mo_arm, mi_seed, mo_seed;
  int mi_avg, mo_avg, mi_last, mo_last;

  function automatic int iir_m(int a, int m, bit s);
    int d, p;
    p = s ? 64 : 4;
    d = m - a;
    if (d >= 0) return a + d / p;
    return a - ((-d + p - 1) / p);
  endfunction

  function automatic longint exp_ratio();
    longint q;
    if (!(mi_seed && mo_seed)) return 0;
    q = (longint'(mo_avg) << 20) / mi_avg;
    if (q > 268435455) q = 268435455;
    return q;
  endfunction

  always @(negedge clk) begin
    cyc++; in_age++; out_age++;
    in_strobe = 1'b0; out_strobe = 1'b0;
    if (gen_on) begin
      in_ph++;
      if (in_ph >= tin) begin
        in_ph = 0; in_strobe = 1'b1; in_age = 0;
        if (mi_arm) begin
          mi_avg  = mi_seed ? iir_m(mi_avg, cyc - mi_last, slow) : cyc - mi_last;
          mi_seed = 1;
        end
        mi_arm = 1; mi_last = cyc;
      end
      out_ph++;
      if (out_ph >= tout) begin
        out_ph = 0; out_strobe = 1'b1; out_age = 0;
        if (mo_arm) begin
          mo_avg  = mo_seed ? iir_m(mo_avg, cyc - mo_last, slow) : cyc - mo_last;
          mo_seed = 1;
        end
        mo_arm = 1; mo_last = cyc;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic chk_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit s);
    gen_on = 0;
    rst_n = 1'b0;
    slow = s;
    mi_arm = 0; mo_arm = 0; mi_seed = 0; mo_seed = 0;
    mi_avg = 0; mo_avg = 0;
    run(3);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic start_gen(int ti, int to);
    tin = ti; tout = to; in_ph = 0; out_ph = 0; gen_on = 1;
  endtask

  task automatic check_ratio(string req);
    int guard = 0;
    while (!(in_age >= 3 && out_age >= 3) && guard < 2000) begin
      tick(); guard++;
    end
    chk_eq(req, "ratio vs model", ratio, exp_ratio());
  endtask

  task automatic idx_steps(int n, int exp_step, string req);
    int prev;
    do tick(); while (out_age != 1);
    prev = phase_idx;
    for (int k = 0; k < n; k++) begin
      do tick(); while (out_age != 1);
      chk_eq(req, "phase_idx step", (phase_idx - prev) & 63, exp_step);
      prev = phase_idx;
    end
  endtask

  // R10 reset values
  task automatic t_reset_state();
    rst_n = 1'b0;
    run(2);
    chk_eq("R10", "ratio in reset", ratio, 0);
    chk_eq("R10", "phase_idx in reset", phase_idx, 0);
    chk_eq("R10", "locked in reset", locked, 0);
    do_reset(0);
    chk_eq("R10", "ratio after reset", ratio, 0);
    chk_eq("R10", "locked after reset", locked, 0);
  endtask

  // R1 first strobe gives no period; R3 basic quotient
  task automatic t_first_period();
    do_reset(0);
    start_gen(30, 30);
    run(35);
    chk_eq("R1", "ratio after single strobes", ratio, 0);
    run(40);
    check_ratio("R1");
    chk_eq("R1", "ratio equal periods", ratio, 1048576);
  endtask

  task automatic t_ratio_value();
    do_reset(0);
    start_gen(25, 20);
    run(200);
    check_ratio("R3");
    chk_eq("R3", "ratio 20/25", ratio, 838860);
  endtask

  // R2 fast vs slow averaging
  task automatic t_gain();
    longint fast_r;
    do_reset(0);
    start_gen(100, 100);
    run(250);
    check_ratio("R2");
    tin = 300;
    run(700);
    check_ratio("R2");
    fast_r = ratio;
    do_reset(1);
    start_gen(100, 100);
    run(250);
    check_ratio("R2");
    tin = 300;
    run(700);
    check_ratio("R2");
    chk_eq("R2", "slow ratio above fast ratio", (ratio > fast_r) ? 1 : 0, 1);
  endtask

  task automatic t_saturate();
    do_reset(0);
    start_gen(4, 1100);
    run(2300);
    check_ratio("R4");
    chk_eq("R4", "saturated ratio", ratio, 268435455);
  endtask

  // R6 step in deadband, R7 trim outside, driven by R5 fill counting
  task automatic t_phase_high();
    do_reset(0);
    start_gen(20, 40);
    run(300);
    idx_steps(4, 0, "R6");
    run(700);
    idx_steps(4, 1, "R7");
  endtask

  task automatic t_phase_low();
    do_reset(0);
    start_gen(40, 20);
    run(300);
    idx_steps(4, 32, "R6");
    run(700);
    idx_steps(4, 31, "R7");
  endtask

  task automatic t_lock();
    do_reset(0);
    start_gen(20, 20);
    run(4000);
    chk_eq("R8", "locked before 256 steady steps", locked, 0);
    run(2500);
    chk_eq("R8", "locked after 256 steady steps", locked, 1);
    tin = 15;
    run(3000);
    chk_eq("R9", "locked after fill left band (R5)", locked, 0);
    run(3000);
    chk_eq("R9", "still unlocked with fill out of band", locked, 0);
  endtask

  initial begin
    t_reset_state();
    t_first_period();
    t_ratio_value();
    t_gain();
    t_saturate();
    t_phase_high();
    t_phase_low();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule